// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes a single DMA transfer (a starting byte address, a byte count and a direction) and breaks it into cache-line-sized memory transactions. It sends them one at a time on a valid/ready request channel. Before it issues the next transaction, it waits for the response to the current one. The first transaction stops at the first line boundary. Every later transaction starts on a line boundary and carries at most one line.

For a write, the host first loads the payload into a source byte buffer through a simple write port. The sequencer then gathers each chunk's bytes into a line-wide data word, placed at their in-line offsets. For a read, each response line is unpacked into a destination byte buffer at the transfer-relative position. The host reads the result back through a registered read port.

Only one transfer may be in flight at a time. A request that arrives while busy is refused. Unsupported request types are rejected, and completion is signalled by a one-cycle pulse.

Top module: `dma_line_seq`

## Requirements
- R1: When idle, a request whose `req_type` is neither 0 (load) nor 1 (store) returns `req_status` = 3 in the following cycle. It sets no busy flag and issues no memory transaction.
- R2: While `busy` is high, any request, of any type, returns `req_status` = 2 in the following cycle. The transfer already in progress continues with unchanged addresses and lengths.
- R3: When idle, a load or store request returns `req_status` = 1 in the following cycle. With a non-zero length, `busy` rises in that same cycle and a first memory transaction follows.
- R4: The first transaction has address = start, with offset = start mod LINE_BYTES. Its length is the whole length if offset + length <= LINE_BYTES; otherwise it is LINE_BYTES - offset.
- R5: Each later transaction starts at start + completed bytes, which is line-aligned. Its length is min(remaining bytes, LINE_BYTES).
- R6: Each transaction also presents its line address, which is the address with the low log2(LINE_BYTES) bits cleared. `mem_req_store` is 1 for a store transfer and 0 for a load transfer.
- R7: A transaction's fields stay stable while `mem_req_valid` is high and `mem_req_ready` is low. No further transaction is presented until a response to the accepted one has arrived.
- R8: For a store, byte (offset + k) of `mem_req_data` (bits 8*(offset+k) up to 8*(offset+k)+7) equals source buffer byte (completed + k), for k below the transaction length.
- R9: For a load, destination buffer byte (completed + k) receives response byte (offset + k), for k below the transaction length.
- R10: After the response that completes the last byte (and, for loads, after unpacking), `busy` falls and `done` pulses for exactly one cycle in the same cycle. No further transaction is issued.
- R11: An accepted request of length 0 returns status 1 and pulses `done` in the following cycle. It never raises `busy` and issues no transaction.
- R12: A response that arrives when no transaction is awaiting one is ignored. It raises `proto_err` for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe |
| req_type | input | 3 | Request type: 0 load, 1 store, others unsupported |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte count (at most MAX_BYTES) |
| req_status | output | 2 | Registered response: 0 none, 1 accepted, 2 busy, 3 bad type |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| src_we | input | 1 | Source buffer write enable |
| src_idx | input | IW | Source buffer byte index |
| src_byte | input | 8 | Source buffer write byte |
| dst_idx | input | IW | Destination buffer read index |
| dst_byte | output | 8 | Destination byte, one cycle after `dst_idx` |
| mem_req_valid | output | 1 | Transaction valid |
| mem_req_ready | input | 1 | Transaction accepted |
| mem_req_store | output | 1 | 1 store, 0 load |
| mem_req_addr | output | AW | Full byte address of the chunk |
| mem_req_line | output | AW | Line-aligned address of the chunk |
| mem_req_len | output | CLW | Chunk length in bytes |
| mem_req_data | output | LBITS | Store data placed at in-line offsets |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_data | input | LBITS | Read response line |
| proto_err | output | 1 | Unexpected response pulse |

## Verification
Directed transfers cover several cases: a one-byte transfer in the last byte of a line, an aligned full line, a full line shifted by one byte, a transfer that exactly fills the tail of a line, a maximum-length aligned transfer and a zero-length transfer. Together they separate the first-chunk clipping rule from the later-chunk rule, and show where an off-by-one in offset or remaining-byte arithmetic appears. Random start addresses, lengths and directions then mix short single-chunk transfers with long ones that span up to five lines. Source bytes are random, and read responses use an address-derived pattern, so a misplaced byte in gather or scatter shows up as a wrong value rather than a matching one. Busy-time requests, bad types and stray responses are injected mid-transfer and when idle, and later chunks are confirmed to be undisturbed.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    STAT_NONE    = 2'd0,
    STAT_OK      = 2'd1,
    STAT_FULL    = 2'd2,
    STAT_BADTYPE = 2'd3
  } seq_stat_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PREP,
    SQ_FILL,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_DRAIN
  } seq_state_e;

  localparam logic [2:0] KIND_LOAD  = 3'd0;
  localparam logic [2:0] KIND_STORE = 3'd1;
endpackage

// File: rtl/dma_byte_ram.sv
module dma_byte_ram #(
  parameter int DEPTH = 256,
  localparam int AWD = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AWD-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic [AWD-1:0] raddr,
  output logic [7:0]     rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int AW = 32,
  parameter int LW = 9,
  parameter int LINE_BYTES = 64,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int CLW = $clog2(LINE_BYTES + 1),
  localparam int CW = (LW > CLW) ? LW : CLW
) (
  input  logic [AW-1:0]   start_addr,
  input  logic [LW-1:0]   total_len,
  input  logic [LW-1:0]   done_bytes,
  output logic [AW-1:0]   chunk_addr,
  output logic [OFFW-1:0] chunk_off,
  output logic [CLW-1:0]  chunk_len
);
  logic [CW-1:0] remain_w;
  logic [CW-1:0] room_w;

  always_comb begin
    chunk_addr = start_addr + AW'(done_bytes);
    chunk_off  = chunk_addr[OFFW-1:0];
    remain_w   = CW'(total_len - done_bytes);
    room_w     = CW'(LINE_BYTES) - CW'(chunk_off);
    chunk_len  = (remain_w < room_w) ? CLW'(remain_w) : CLW'(room_w);
  end
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES = 256,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int CLW = $clog2(LINE_BYTES + 1),
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int IW = $clog2(MAX_BYTES),
  localparam int LBITS = LINE_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_type,
  input  logic [AW-1:0]    req_addr,
  input  logic [LW-1:0]    req_len,
  output logic [1:0]       req_status,
  output logic             busy,
  output logic             done,
  input  logic             src_we,
  input  logic [IW-1:0]    src_idx,
  input  logic [7:0]       src_byte,
  input  logic [IW-1:0]    dst_idx,
  output logic [7:0]       dst_byte,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_store,
  output logic [AW-1:0]    mem_req_addr,
  output logic [AW-1:0]    mem_req_line,
  output logic [CLW-1:0]   mem_req_len,
  output logic [LBITS-1:0] mem_req_data,
  input  logic             mem_rsp_valid,
  input  logic [LBITS-1:0] mem_rsp_data,
  output logic             proto_err
);
  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);

  seq_state_e       st_q;
  logic [AW-1:0]    start_q;
  logic [LW-1:0]    len_q;
  logic             wr_q;
  logic [LW-1:0]    issued_q;
  logic [LW-1:0]    compl_q;
  logic [LW-1:0]    pos_q;
  logic [OFFW-1:0]  cur_off;
  logic [CLW-1:0]   cur_len;
  logic [CLW-1:0]   cnt_q;
  logic             rd_vld_q;
  logic [CLW-1:0]   rd_k_q;
  logic [LBITS-1:0] line_q;

  logic [AW-1:0]    c_addr;
  logic [OFFW-1:0]  c_off;
  logic [CLW-1:0]   c_len;
  logic [IW-1:0]    src_raddr;
  logic [7:0]       src_rdata;
  logic             dst_we;
  logic [IW-1:0]    dst_waddr;
  logic [7:0]       dst_wdata;
  logic [OFFW-1:0]  fill_sel;
  logic [OFFW-1:0]  drain_sel;
  logic             type_ok;

  dma_chunk_calc #(.AW(AW), .LW(LW), .LINE_BYTES(LINE_BYTES)) calc_i (
    .start_addr (start_q),
    .total_len  (len_q),
    .done_bytes (compl_q),
    .chunk_addr (c_addr),
    .chunk_off  (c_off),
    .chunk_len  (c_len)
  );

  dma_byte_ram #(.DEPTH(MAX_BYTES)) src_ram_i (
    .clk   (clk),
    .we    (src_we),
    .waddr (src_idx),
    .wdata (src_byte),
    .raddr (src_raddr),
    .rdata (src_rdata)
  );

  dma_byte_ram #(.DEPTH(MAX_BYTES)) dst_ram_i (
    .clk   (clk),
    .we    (dst_we),
    .waddr (dst_waddr),
    .wdata (dst_wdata),
    .raddr (dst_idx),
    .rdata (dst_byte)
  );

  always_comb begin
    type_ok   = (req_type == KIND_LOAD) || (req_type == KIND_STORE);
    src_raddr = IW'(compl_q) + IW'(cnt_q);
    fill_sel  = cur_off + rd_k_q[OFFW-1:0];
    drain_sel = cur_off + cnt_q[OFFW-1:0];
    dst_we    = (st_q == SQ_DRAIN);
    dst_waddr = IW'(pos_q) + IW'(cnt_q);
    dst_wdata = line_q[{drain_sel, 3'b000} +: 8];
  end

  assign mem_req_data = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= SQ_IDLE;
      start_q       <= '0;
      len_q         <= '0;
      wr_q          <= 1'b0;
      issued_q      <= '0;
      compl_q       <= '0;
      pos_q         <= '0;
      cur_off       <= '0;
      cur_len       <= '0;
      cnt_q         <= '0;
      rd_vld_q      <= 1'b0;
      rd_k_q        <= '0;
      line_q        <= '0;
      req_status    <= STAT_NONE;
      busy          <= 1'b0;
      done          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_store <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_line  <= '0;
      mem_req_len   <= '0;
      proto_err     <= 1'b0;
    end else begin
      done       <= 1'b0;
      req_status <= STAT_NONE;
      proto_err  <= mem_rsp_valid && (st_q != SQ_WAIT);

      if (req_valid) begin
        if (st_q != SQ_IDLE) req_status <= STAT_FULL;
        else if (!type_ok)   req_status <= STAT_BADTYPE;
        else                 req_status <= STAT_OK;
      end

      unique case (st_q)
        SQ_IDLE: begin
          if (req_valid && type_ok) begin
            start_q  <= req_addr;
            len_q    <= req_len;
            wr_q     <= (req_type == KIND_STORE);
            issued_q <= '0;
            compl_q  <= '0;
            if (req_len == '0) begin
              done <= 1'b1;
            end else begin
              busy <= 1'b1;
              st_q <= SQ_PREP;
            end
          end
        end
        SQ_PREP: begin
          mem_req_addr  <= c_addr;
          mem_req_line  <= c_addr & ~LINE_MASK;
          mem_req_len   <= c_len;
          mem_req_store <= wr_q;
          cur_off       <= c_off;
          cur_len       <= c_len;
          pos_q         <= compl_q;
          cnt_q         <= '0;
          rd_vld_q      <= 1'b0;
          line_q        <= '0;
          if (wr_q) begin
            st_q <= SQ_FILL;
          end else begin
            st_q          <= SQ_ISSUE;
            mem_req_valid <= 1'b1;
          end
        end
        SQ_FILL: begin
          if (cnt_q < cur_len) begin
            cnt_q    <= cnt_q + 1'b1;
            rd_k_q   <= cnt_q;
            rd_vld_q <= 1'b1;
          end else begin
            rd_vld_q <= 1'b0;
          end
          if (rd_vld_q) line_q[{fill_sel, 3'b000} +: 8] <= src_rdata;
          if ((cnt_q == cur_len) && rd_vld_q) begin
            st_q          <= SQ_ISSUE;
            mem_req_valid <= 1'b1;
          end
        end
        SQ_ISSUE: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            issued_q      <= issued_q + LW'(cur_len);
            st_q          <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (mem_rsp_valid) begin
            compl_q <= issued_q;
            if (!wr_q) begin
              line_q <= mem_rsp_data;
              cnt_q  <= '0;
              st_q   <= SQ_DRAIN;
            end else if (issued_q == len_q) begin
              busy <= 1'b0;
              done <= 1'b1;
              st_q <= SQ_IDLE;
            end else begin
              st_q <= SQ_PREP;
            end
          end
        end
        SQ_DRAIN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == cur_len - 1'b1) begin
            if (compl_q == len_q) begin
              busy <= 1'b0;
              done <= 1'b1;
              st_q <= SQ_IDLE;
            end else begin
              st_q <= SQ_PREP;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_line_seq_chk.sv
module dma_line_seq_chk #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES = 256,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int CLW = $clog2(LINE_BYTES + 1),
  localparam int LBITS = LINE_BYTES * 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       req_status,
  input logic             busy,
  input logic             done,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_store,
  input logic [AW-1:0]    mem_req_addr,
  input logic [CLW-1:0]   mem_req_len,
  input logic [LBITS-1:0] mem_req_data,
  input logic             mem_rsp_valid,
  input logic             proto_err
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_len) && $stable(mem_req_data) && $stable(mem_req_store));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  full_reply_chk: assert property (@(posedge clk) disable iff (rst)
    busy && req_valid |=> req_status == 2'd2);

  // R3
  status_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (req_status != 2'd0) |-> $past(req_valid));

  // R4
  chunk_fit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_len != '0) &&
      ((CLW+1)'(mem_req_addr[OFFW-1:0]) + (CLW+1)'(mem_req_len) <= (CLW+1)'(LINE_BYTES)));

  // R12
  stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(mem_rsp_valid));
endmodule

bind dma_line_seq dma_line_seq_chk #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_status    (req_status),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_store (mem_req_store),
  .mem_req_addr  (mem_req_addr),
  .mem_req_len   (mem_req_len),
  .mem_req_data  (mem_req_data),
  .mem_rsp_valid (mem_rsp_valid),
  .proto_err     (proto_err)
);

// File: tb/dma_line_seq_tb.sv
`timescale 1ns/1ps
module dma_line_seq_tb_top;
  localparam int AW = 32;
  localparam int LB = 64;
  localparam int MAXB = 256;
  localparam int CLW = $clog2(LB + 1);
  localparam int LW = $clog2(MAXB + 1);
  localparam int IW = $clog2(MAXB);
  localparam int LBITS = LB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_type = '0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [1:0] req_status;
  logic busy, done;
  logic src_we = 1'b0;
  logic [IW-1:0] src_idx = '0;
  logic [7:0] src_byte = '0;
  logic [IW-1:0] dst_idx = '0;
  logic [7:0] dst_byte;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic mem_req_store;
  logic [AW-1:0] mem_req_addr, mem_req_line;
  logic [CLW-1:0] mem_req_len;
  logic [LBITS-1:0] mem_req_data;
  logic mem_rsp_valid = 1'b0;
  logic [LBITS-1:0] mem_rsp_data = '0;
  logic proto_err;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] src_mem [MAXB];

  always #2.5 clk = ~clk;

  dma_line_seq #(.AW(AW), .LINE_BYTES(LB), .MAX_BYTES(MAXB)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic send_req(input logic [2:0] t, input logic [AW-1:0] a, input int n);
    req_valid = 1'b1; req_type = t; req_addr = a; req_len = LW'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_xfer(input logic [AW-1:0] start, input int len, input bit wr, input bit probe);
    int done_b;
    int n;
    if (wr) begin
      for (int k = 0; k < len; k++) begin
        src_mem[k] = 8'($urandom);
        src_we = 1'b1; src_idx = IW'(k); src_byte = src_mem[k];
        @(negedge clk);
      end
      src_we = 1'b0;
    end
    send_req(wr ? 3'd1 : 3'd0, start, len);
    chk(req_status == 2'd1, "R3 accept status", req_status, 1);
    if (len == 0) begin
      chk(done && !busy, "R11 zero-length done", {done, busy}, 2'b10);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!mem_req_valid && !busy, "R11 no transaction", {mem_req_valid, busy}, 0);
      end
      return;
    end
    chk(busy, "R3 busy rises", busy, 1);
    if (probe) begin
      send_req(3'd2, ~start, 7);
      chk(req_status == 2'd2, "R2 busy refusal", req_status, 2);
    end
    done_b = 0;
    while (done_b < len) begin
      logic [AW-1:0] ea;
      int off, clen;
      logic [LBITS-1:0] cap;
      n = 0;
      while (!mem_req_valid && n < 400) begin
        @(negedge clk); n++;
      end
      chk(mem_req_valid, "R7 transaction presented", mem_req_valid, 1);
      if (!mem_req_valid) return;
      ea = start + AW'(done_b);
      off = int'(ea % LB);
      clen = (len - done_b < LB - off) ? len - done_b : LB - off;
      chk(mem_req_addr == ea, done_b == 0 ? "R4 first addr" : "R5 later addr", mem_req_addr, ea);
      chk(int'(mem_req_len) == clen, done_b == 0 ? "R4 first len" : "R5 later len", mem_req_len, clen);
      chk(mem_req_line == (ea & ~AW'(LB - 1)), "R6 line addr", mem_req_line, ea & ~AW'(LB - 1));
      chk(mem_req_store == wr, "R6 store flag", mem_req_store, wr);
      if (wr)
        for (int k = 0; k < clen; k++)
          chk(mem_req_data[(off + k) * 8 +: 8] == src_mem[done_b + k], "R8 store byte",
              mem_req_data[(off + k) * 8 +: 8], src_mem[done_b + k]);
      cap = mem_req_data;
      for (int d = int'($urandom_range(0, 3)); d > 0; d--) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ea && mem_req_data == cap, "R7 hold", mem_req_addr, ea);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(!mem_req_valid, "R7 drop after accept", mem_req_valid, 0);
      for (int d = int'($urandom_range(0, 4)); d > 0; d--) begin
        @(negedge clk);
        chk(!mem_req_valid, "R7 one outstanding", mem_req_valid, 0);
      end
      for (int j = 0; j < LB; j++)
        mem_rsp_data[j * 8 +: 8] = wr ? 8'($urandom) : mem_byte((ea & ~AW'(LB - 1)) + AW'(j));
      mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      done_b += clen;
    end
    n = 0;
    while (!done && n < 200) begin
      chk(!mem_req_valid, "R10 no extra transaction", mem_req_valid, 0);
      @(negedge clk); n++;
    end
    chk(done && !busy && !proto_err, "R10 done with busy low", {done, busy, proto_err}, 3'b100);
    @(negedge clk);
    chk(!done, "R10 done single pulse", done, 0);
    if (!wr)
      for (int k = 0; k < len; k++) begin
        dst_idx = IW'(k);
        @(negedge clk);
        chk(dst_byte == mem_byte(start + AW'(k)), "R9 load byte", dst_byte, mem_byte(start + AW'(k)));
      end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req_valid && req_status == 0 && !proto_err, "R3 reset state",
        {busy, done, mem_req_valid, req_status, proto_err}, 0);

    send_req(3'd3, 32'h100, 8);
    chk(req_status == 2'd3 && !busy, "R1 bad type status", req_status, 3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!mem_req_valid && !busy, "R1 nothing issued", {mem_req_valid, busy}, 0);
    end
    send_req(3'd6, 32'h40, 64);
    chk(req_status == 2'd3 && !busy, "R1 locked type status", req_status, 3);

    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(proto_err && !busy, "R12 stray response flagged", proto_err, 1);
    @(negedge clk);
    chk(!proto_err && !busy, "R12 flag pulse", proto_err, 0);

    run_xfer(32'h0000_103F, 1, 0, 1);
    run_xfer(32'h0000_2000, 64, 1, 0);
    run_xfer(32'h0000_3001, 64, 0, 1);
    run_xfer(32'h0000_403C, 4, 1, 0);
    run_xfer(32'h0000_5000, MAXB, 0, 0);
    run_xfer(32'h0000_6011, MAXB, 1, 1);
    run_xfer(32'h0000_7000, 0, 0, 0);

    for (int i = 0; i < 36; i++)
      run_xfer($urandom, int'($urandom_range(1, MAXB)), 1'($urandom_range(0, 1)), (i % 4) == 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule